// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Decoder

This block sits on the device side of a removable storage card running in memory-card or I/O-card mode. It watches the host's register-select, two chip enables, the address, and four strobes: memory read, memory write, I/O read and I/O write. From these it works out which internal space the host is reaching. That space is attribute memory, a register file reached through I/O cycles, or the same register file reached through common-memory cycles.

The two chip enables choose the transfer width. The choices are a single byte on the lower lane, a full 16-bit word, or the odd byte alone on the upper lane. The block places the even and odd bytes on the right lanes and raises a separate output enable for each lane, so the pad ring can build the bidirectional bus from `d_out`, `d_in` and the two enables. Attribute memory holds a fixed 256-byte card information area and a few writable configuration bytes. Only its even byte positions carry data. Writes are committed inside a system clock domain when the write strobe is released.

Top module: `pccard_lane_steer`

## Requirements
- R1: When `ce1_n` and `ce2_n` are both high, neither lane output enable is asserted, and a write strobe in that state changes no stored byte.
- R2: With `ce1_n` low and `ce2_n` high (byte width), only the lower lane is driven on reads. It carries the byte at the address with `a[0]` selecting even (0) or odd (1). A write stores `d_in[7:0]` into that byte.
- R3: With both chip enables low (word width), `a[0]` is ignored. A read drives the even byte on bits 7:0 and the odd byte on bits 15:8. A write stores both halves of `d_in` the same way.
- R4: With `ce1_n` high and `ce2_n` low (odd width), reads drive only the upper lane with the odd byte of the addressed word. A write stores `d_in[15:8]` into the odd byte and leaves the even byte alone.
- R5: Attribute space is selected by `reg_n` low with `oe_n` or `we_n`. Every odd byte position reads as 8'h00 on whichever lane carries it, and writes to odd positions are dropped.
- R6: Attribute addresses with `a[9]`=0 form the 256-byte information area, indexed by `a[8:1]`. The byte at index i reads as (7*i + 8'h11) mod 256, and writes there have no effect.
- R7: Attribute addresses with `a[9]`=1 reach 4 writable configuration bytes, selected by `a[2:1]`. These bytes clear to 8'h00 on reset.
- R8: An 8-byte register file, byte-addressed by `a[2:0]`, is reached both by `reg_n` low with `iord_n`/`iowr_n` and by `reg_n` high with `oe_n`/`we_n`. Both paths share one storage, which clears on reset. With `reg_n` high, the I/O strobes produce no access.
- R9: If more than one of `oe_n`, `we_n`, `iord_n` and `iowr_n` is low, there is no access: no lane is driven and nothing is written.
- R10: A write takes effect at the first rising clock edge at which its strobe is no longer asserted. It uses the data and address sampled at the last rising edge that still saw the strobe. Read data follows the stored contents combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_n | input | 1 | Register-space select, active low |
| ce1_n | input | 1 | Lower chip enable, active low |
| ce2_n | input | 1 | Upper chip enable, active low |
| a | input | ADDR_W | Host byte address, `a[0]` is the byte select |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| d_in | input | 16 | Data from the host bus |
| d_out | output | 16 | Data toward the host bus |
| d_oe_lo | output | 1 | Output enable for bits 7:0 |
| d_oe_hi | output | 1 | Output enable for bits 15:8 |

## Verification
The hardest case to reach is the commit timing of a write. The stored value must come from the last clock edge that still saw the strobe, and it must become visible only one edge after release. To get there, the stimulus changes the write data between two edges of a single long strobe. It then swaps straight into a read at the release point and samples once before and once after the committing edge. Dropped writes are shown by reading the same location back through the normal read path. These are writes to odd attribute positions, to the information area, in standby, and with conflicting strobes.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_ATTR = 2'd1,
    SP_TF   = 2'd2
  } space_e;

  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_BYTE = 2'd1,
    W_WORD = 2'd2,
    W_ODD  = 2'd3
  } width_e;

  typedef struct packed {
    space_e     space;
    logic       we_even;
    logic       we_odd;
    logic [7:0] wd_even;
    logic [7:0] wd_odd;
  } wr_fields_t;

  // Fixed content of the card information area.
  function automatic logic [7:0] cis_byte(input logic [15:0] idx);
    logic [15:0] v;
    v = idx * 16'd7 + 16'h0011;
    return v[7:0];
  endfunction

endpackage

// File: rtl/pcl_decode.sv
module pcl_decode
  import pcl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic         reg_n,
  input  logic         ce1_n,
  input  logic         ce2_n,
  input  logic         a0,
  input  logic         oe_n,
  input  logic         we_n,
  input  logic         iord_n,
  input  logic         iowr_n,
  input  logic [15:0]  d_in,
  output space_e       space,
  output logic         rd_en,
  output logic         wr_en,
  output logic         lane_lo_oe,
  output logic         lane_hi_oe,
  output logic         lo_sel_odd,
  output wr_fields_t   wf
);

  width_e     width;
  logic [3:0] stb;
  logic       one_stb;
  logic       mem_stb;
  logic       io_stb;
  logic       rd_stb;
  logic       wr_stb;

  always_comb begin
    unique case ({ce1_n, ce2_n})
      2'b11:   width = W_NONE;
      2'b01:   width = W_BYTE;
      2'b00:   width = W_WORD;
      default: width = W_ODD;
    endcase
  end

  assign stb     = {~oe_n, ~we_n, ~iord_n, ~iowr_n};
  assign one_stb = (stb != 4'b0000) && ((stb & (stb - 4'd1)) == 4'b0000);
  assign mem_stb = ~oe_n | ~we_n;
  assign io_stb  = ~iord_n | ~iowr_n;
  assign rd_stb  = ~oe_n | ~iord_n;
  assign wr_stb  = ~we_n | ~iowr_n;

  always_comb begin
    space = SP_NONE;
    if (one_stb && (width != W_NONE)) begin
      if (mem_stb)     space = reg_n ? SP_TF : SP_ATTR;
      else if (io_stb) space = reg_n ? SP_NONE : SP_TF;
    end
  end

  assign rd_en = (space != SP_NONE) && rd_stb;
  assign wr_en = (space != SP_NONE) && wr_stb;

  assign lane_lo_oe = rd_en && ((width == W_BYTE) || (width == W_WORD));
  assign lane_hi_oe = rd_en && ((width == W_WORD) || (width == W_ODD));
  assign lo_sel_odd = (width == W_BYTE) && a0;

  always_comb begin
    wf.space   = space;
    wf.we_even = wr_en && (((width == W_BYTE) && !a0) || (width == W_WORD));
    wf.we_odd  = wr_en && (((width == W_BYTE) && a0) || (width == W_WORD) ||
                           (width == W_ODD));
    wf.wd_even = d_in[7:0];
    wf.wd_odd  = (width == W_BYTE) ? d_in[7:0] : d_in[15:8];
  end

endmodule

// File: rtl/pcl_wrcap.sv
module pcl_wrcap
  import pcl_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WIDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wr_fields_t        wf_in,
  input  logic [WIDX_W-1:0] widx_in,
  output logic              commit,
  output wr_fields_t        wf_q,
  output logic [WIDX_W-1:0] widx_q
);

  logic              wr_q;
  logic              wr_d;
  wr_fields_t        wf_d;
  logic [WIDX_W-1:0] widx_d;

  always_comb begin
    wr_d   = wr_en;
    wf_d   = wf_q;
    widx_d = widx_q;
    if (wr_en) begin
      wf_d   = wf_in;
      widx_d = widx_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wf_q   <= '0;
      widx_q <= '0;
    end else begin
      wr_q   <= wr_d;
      wf_q   <= wf_d;
      widx_q <= widx_d;
    end
  end

  assign commit = wr_q && !wr_en;

endmodule

// File: rtl/pcl_store.sv
module pcl_store
  import pcl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CFG_N  = 4,
  parameter int TF_N   = 8,
  localparam int WIDX_W = ADDR_W - 1,
  localparam int CFG_AW = $clog2(CFG_N),
  localparam int TF_AW  = $clog2(TF_N),
  localparam int TF_WAW = TF_AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  wr_fields_t        c_wf,
  input  logic [WIDX_W-1:0] c_widx,
  input  space_e            r_space,
  input  logic [WIDX_W-1:0] r_widx,
  output logic [7:0]        rd_even,
  output logic [7:0]        rd_odd
);

  logic [7:0] cfg_q [CFG_N];
  logic [7:0] cfg_d [CFG_N];
  logic [7:0] tf_q  [TF_N];
  logic [7:0] tf_d  [TF_N];

  logic cfg_wr;
  logic tf_wr;
  logic unused_cw;

  assign cfg_wr    = commit && (c_wf.space == SP_ATTR) && c_widx[WIDX_W-1] && c_wf.we_even;
  assign tf_wr     = commit && (c_wf.space == SP_TF);
  assign unused_cw = ^c_widx;

  for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
    always_comb begin
      cfg_d[i] = cfg_q[i];
      if (cfg_wr && (c_widx[CFG_AW-1:0] == CFG_AW'(i))) cfg_d[i] = c_wf.wd_even;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= 8'h00;
      else        cfg_q[i] <= cfg_d[i];
    end
  end

  for (genvar j = 0; j < TF_N; j++) begin : g_tf
    localparam bit IS_ODD = (j % 2) == 1;
    localparam int WORD   = j / 2;
    logic lane_we;
    assign lane_we = IS_ODD ? c_wf.we_odd : c_wf.we_even;
    always_comb begin
      tf_d[j] = tf_q[j];
      if (tf_wr && lane_we && (c_widx[TF_WAW-1:0] == TF_WAW'(WORD)))
        tf_d[j] = IS_ODD ? c_wf.wd_odd : c_wf.wd_even;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tf_q[j] <= 8'h00;
      else        tf_q[j] <= tf_d[j];
    end
  end

  always_comb begin
    rd_even = 8'h00;
    rd_odd  = 8'h00;
    unique case (r_space)
      SP_ATTR: begin
        if (!r_widx[WIDX_W-1]) rd_even = cis_byte(16'(r_widx[WIDX_W-2:0]));
        else                   rd_even = cfg_q[r_widx[CFG_AW-1:0]];
      end
      SP_TF: begin
        rd_even = tf_q[{r_widx[TF_WAW-1:0], 1'b0}];
        rd_odd  = tf_q[{r_widx[TF_WAW-1:0], 1'b1}];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
  import pcl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CFG_N  = 4,
  parameter int TF_N   = 8,
  localparam int WIDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_n,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic [ADDR_W-1:0] a,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              iord_n,
  input  logic              iowr_n,
  input  logic [15:0]       d_in,
  output logic [15:0]       d_out,
  output logic              d_oe_lo,
  output logic              d_oe_hi
);

  logic [1:0]  rs_q;
  logic        rst_int_n;

  space_e      space;
  logic        rd_en;
  logic        wr_en;
  logic        lane_lo_oe;
  logic        lane_hi_oe;
  logic        lo_sel_odd;
  wr_fields_t  wf;
  logic        commit;
  wr_fields_t  c_wf;
  logic [WIDX_W-1:0] c_widx;
  logic [7:0]  rd_even;
  logic [7:0]  rd_odd;
  logic        unused_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  pcl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_n      (reg_n),
    .ce1_n      (ce1_n),
    .ce2_n      (ce2_n),
    .a0         (a[0]),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .iord_n     (iord_n),
    .iowr_n     (iowr_n),
    .d_in       (d_in),
    .space      (space),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .lane_lo_oe (lane_lo_oe),
    .lane_hi_oe (lane_hi_oe),
    .lo_sel_odd (lo_sel_odd),
    .wf         (wf)
  );

  pcl_wrcap #(.ADDR_W(ADDR_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wf_in   (wf),
    .widx_in (a[ADDR_W-1:1]),
    .commit  (commit),
    .wf_q    (c_wf),
    .widx_q  (c_widx)
  );

  pcl_store #(.ADDR_W(ADDR_W), .CFG_N(CFG_N), .TF_N(TF_N)) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .commit  (commit),
    .c_wf    (c_wf),
    .c_widx  (c_widx),
    .r_space (space),
    .r_widx  (a[ADDR_W-1:1]),
    .rd_even (rd_even),
    .rd_odd  (rd_odd)
  );

  assign unused_rd  = rd_en;
  assign d_oe_lo    = lane_lo_oe;
  assign d_oe_hi    = lane_hi_oe;
  assign d_out[7:0]  = lane_lo_oe ? (lo_sel_odd ? rd_odd : rd_even) : 8'h00;
  assign d_out[15:8] = lane_hi_oe ? rd_odd : 8'h00;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_n,
  input logic        ce1_n,
  input logic        ce2_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        iord_n,
  input logic        iowr_n,
  input logic [15:0] d_out,
  input logic        d_oe_lo,
  input logic        d_oe_hi
);

  p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ce2_n) |-> (!d_oe_lo && !d_oe_hi));

  p_byte_upper_z_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && ce2_n) |-> !d_oe_hi);

  p_word_both_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && !ce2_n && !oe_n && we_n && iord_n && iowr_n) |-> (d_oe_lo && d_oe_hi));

  p_odd_lower_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && !ce2_n) |-> !d_oe_lo);

  p_attr_odd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_n && !oe_n && d_oe_hi) |-> (d_out[15:8] == 8'h00));

  p_io_reg_high_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_n && oe_n && we_n && (!iord_n || !iowr_n)) |-> (!d_oe_lo && !d_oe_hi));

  p_conflict_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!oe_n || !iord_n) && (!we_n || !iowr_n)) |-> (!d_oe_lo && !d_oe_hi));

endmodule

bind pccard_lane_steer pcl_checker u_chk (.*);

// File: tb/pccard_lane_steer_test.sv
`timescale 1ns/1ps
module pccard_lane_steer_test;

  typedef struct packed {
    logic        wr;
    logic        reg_n;
    logic        ce1_n;
    logic        ce2_n;
    logic        io;
    logic [9:0]  addr;
    logic [15:0] data;
    logic        elo;
    logic        ehi;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,10'h000,16'hB2A1,1'b0,1'b0,4'd8},  // R8 io word write
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'h000,16'hB2A1,1'b1,1'b1,4'd3},  // R3 mem word read
    '{1'b1,1'b0,1'b0,1'b1,1'b1,10'h003,16'h00C3,1'b0,1'b0,4'd2},  // R2 byte write odd
    '{1'b0,1'b1,1'b0,1'b1,1'b0,10'h003,16'h00C3,1'b1,1'b0,4'd2},  // R2 byte read odd
    '{1'b1,1'b1,1'b1,1'b0,1'b0,10'h004,16'hD500,1'b0,1'b0,4'd4},  // R4 odd write
    '{1'b0,1'b0,1'b0,1'b0,1'b1,10'h004,16'hD500,1'b1,1'b1,4'd8},  // R8 io word read
    '{1'b0,1'b0,1'b1,1'b0,1'b1,10'h002,16'hC300,1'b0,1'b1,4'd4},  // R4 odd read
    '{1'b0,1'b1,1'b0,1'b1,1'b0,10'h001,16'h00B2,1'b1,1'b0,4'd2},  // R2 byte read odd
    '{1'b1,1'b0,1'b0,1'b0,1'b0,10'h202,16'h77E6,1'b0,1'b0,4'd7},  // R7 cfg word write
    '{1'b0,1'b0,1'b0,1'b0,1'b0,10'h202,16'h00E6,1'b1,1'b1,4'd5},  // R5 odd reads zero
    '{1'b0,1'b0,1'b0,1'b1,1'b0,10'h203,16'h0000,1'b1,1'b0,4'd5},  // R5 byte odd zero
    '{1'b0,1'b0,1'b1,1'b0,1'b0,10'h202,16'h0000,1'b0,1'b1,4'd5},  // R5 odd width zero
    '{1'b1,1'b0,1'b0,1'b1,1'b0,10'h004,16'h0099,1'b0,1'b0,4'd6},  // R6 write dropped
    '{1'b0,1'b0,1'b0,1'b0,1'b0,10'h004,16'h001F,1'b1,1'b1,4'd6},  // R6 index 2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,10'h1FE,16'h000A,1'b1,1'b0,4'd6},  // R6 index 255
    '{1'b0,1'b0,1'b1,1'b1,1'b1,10'h000,16'h0000,1'b0,1'b0,4'd1},  // R1 standby read
    '{1'b1,1'b0,1'b1,1'b1,1'b1,10'h000,16'hFFFF,1'b0,1'b0,4'd1},  // R1 standby write
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'h000,16'hB2A1,1'b1,1'b1,4'd1},  // R1 unchanged
    '{1'b1,1'b0,1'b0,1'b1,1'b1,10'h006,16'h1166,1'b0,1'b0,4'd2},  // R2 byte write even
    '{1'b0,1'b0,1'b0,1'b0,1'b1,10'h006,16'h0066,1'b1,1'b1,4'd2},  // R2 odd untouched
    '{1'b0,1'b1,1'b0,1'b0,1'b1,10'h000,16'h0000,1'b0,1'b0,4'd8}   // R8 io with reg high
  };

  logic        clk;
  logic        rst_n;
  logic        reg_n, ce1_n, ce2_n;
  logic [9:0]  a;
  logic        oe_n, we_n, iord_n, iowr_n;
  logic [15:0] d_in;
  logic [15:0] d_out;
  logic        d_oe_lo, d_oe_hi;

  int checks;
  int fails;
  bit done;

  pccard_lane_steer uut (
    .clk(clk), .rst_n(rst_n), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .a(a), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .d_in(d_in), .d_out(d_out), .d_oe_lo(d_oe_lo), .d_oe_hi(d_oe_hi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic idle();
    reg_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1; a = '0;
    oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1; d_in = '0;
  endtask

  task automatic check(input string tag, input logic elo, input logic ehi,
                       input logic [15:0] edata);
    logic [15:0] mask;
    logic [17:0] act, exp;
    mask = {{8{d_oe_hi}}, {8{d_oe_lo}}};
    act  = {d_oe_lo, d_oe_hi, d_out & mask};
    exp  = {elo, ehi, edata};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: oe_lo/oe_hi/data actual %b%b/%h expected %b%b/%h",
               tag, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic setup(input logic r, input logic c1, input logic c2,
                       input logic [9:0] ad);
    reg_n = r; ce1_n = c1; ce2_n = c2; a = ad;
  endtask

  task automatic do_write(input logic r, input logic c1, input logic c2,
                          input logic io, input logic [9:0] ad, input logic [15:0] dv);
    @(negedge clk);
    setup(r, c1, c2, ad);
    d_in = dv;
    if (io) iowr_n = 1'b0; else we_n = 1'b0;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic do_read(input string tag, input logic r, input logic c1,
                         input logic c2, input logic io, input logic [9:0] ad,
                         input logic elo, input logic ehi, input logic [15:0] ed);
    @(negedge clk);
    setup(r, c1, c2, ad);
    if (io) iord_n = 1'b0; else oe_n = 1'b0;
    #2;
    check(tag, elo, ehi, ed);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    do_read("R8 reset file", 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 1'b1, 1'b1, 16'h0000);
    do_read("R7 reset cfg", 1'b0, 1'b0, 1'b0, 1'b0, 10'h200, 1'b1, 1'b1, 16'h0000);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr)
        do_write(VEC[i].reg_n, VEC[i].ce1_n, VEC[i].ce2_n, VEC[i].io,
                 VEC[i].addr, VEC[i].data);
      else
        do_read($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].reg_n,
                VEC[i].ce1_n, VEC[i].ce2_n, VEC[i].io, VEC[i].addr,
                VEC[i].elo, VEC[i].ehi, VEC[i].data);
    end

    // R9: conflicting read strobes and write strobe
    @(negedge clk);
    setup(1'b0, 1'b0, 1'b0, 10'h000);
    oe_n = 1'b0; iowr_n = 1'b0; d_in = 16'h1234;
    #2;
    check("R9 conflict read", 1'b0, 1'b0, 16'h0000);
    @(negedge clk);
    idle();
    @(negedge clk);
    setup(1'b1, 1'b0, 1'b0, 10'h000);
    we_n = 1'b0; iord_n = 1'b0; d_in = 16'h5678;
    @(negedge clk);
    idle();
    @(negedge clk);
    do_read("R9 conflict write dropped", 1'b1, 1'b0, 1'b0, 1'b0, 10'h000,
            1'b1, 1'b1, 16'hB2A1);

    // R10: data from the last edge under the strobe, commit one edge after release
    @(negedge clk);
    setup(1'b0, 1'b0, 1'b0, 10'h002);
    iowr_n = 1'b0; d_in = 16'h1111;
    @(negedge clk);
    d_in = 16'h3344;
    @(negedge clk);
    iowr_n = 1'b1;
    reg_n = 1'b1; oe_n = 1'b0;
    #2;
    check("R10 before commit edge", 1'b1, 1'b1, 16'hC300);
    @(negedge clk);
    #2;
    check("R10 after commit edge", 1'b1, 1'b1, 16'h3344);
    @(negedge clk);
    idle();

    // R8 / R7: reset clears written storage
    do_reset();
    do_read("R8 cleared by reset", 1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 1'b1, 1'b1, 16'h0000);
    do_read("R7 cleared by reset", 1'b0, 1'b0, 1'b0, 1'b0, 10'h202, 1'b1, 1'b1, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule